// File: doc/BRIEF.md
# Golden-Envelope Deviation Scorer

This block grades one converter output record against a band learned from known-good records. Each record is a single reconstructed period of `DEPTH` sample codes, streamed one code per accepted cycle. In a learn run every value widens a stored per-index band: the largest value seen at that index becomes its upper edge and the smallest becomes its lower edge. Several good runs are fed in sequence, covering every corner case, so the band ends up holding the full spread of acceptable behaviour.

In a test run each value is compared with the band at its own index. A value above the upper edge adds its distance from that edge. A value below the lower edge adds its distance from that edge. A value inside the band adds nothing. The record is split into four programmable index windows. For each window the block sums the excess and the band width, divides the two with a shift-subtract divider, and reports the result in tenths of a percent together with a fail flag against a programmable limit. A mode bit chooses between the raw codes and the signed difference between each code and the one before it. The difference is a monotonic stand-in for the slope angle.

The controller has four states. `ST_IDLE` waits for `start`. A clear command re-initialises the band and the block stays in `ST_IDLE`. A learn or test command moves it to `ST_COLLECT`, which accepts `DEPTH` codes. After the last code a learn run returns to `ST_IDLE` and a test run enters `ST_LOAD` for window 0. `ST_LOAD` hands the window's sums to the divider and always moves to `ST_WAIT`. When the divider finishes, `ST_WAIT` emits that window's result and goes to `ST_LOAD` for the next window, or to `ST_IDLE` after the last window.

Top module: `envelope_scorer`

## Requirements
- R1: After reset `score_valid`, `score` and `fail` are 0. The band is empty, meaning upper edge = most negative and lower edge = most positive of the internal `DATA_W+2`-bit signed value.
- R2: `start` with `op`=0 (clear) in `ST_IDLE` returns every index of the band to the empty state, so later learn runs see none of the earlier records.
- R3: `start` with `op`=1 (learn) takes `DEPTH` codes. At each index the upper edge becomes the maximum and the lower edge the minimum of all values learned since the last clear.
- R4: In a test run (`op`=2), a value above the upper edge at its index contributes value minus upper edge.
- R5: In a test run, a value below the lower edge contributes lower edge minus value.
- R6: In a test run, a value inside the band, edges included, contributes zero.
- R7: The score of each window is floor(1000 × summed excess / summed band width) in units of 0.1 %, saturated at 2^`SCORE_W`−1. The band width at an index is upper minus lower edge, or 0 where the band is empty.
- R8: Window k covers indices `sec_lo[k*6+:6]` to `sec_hi[k*6+:6]`, both inclusive, and windows may overlap. A test run emits one single-cycle `score_valid` pulse per window, in the order k = 0, 1, 2, 3, with k on `score_sec`.
- R9: With `slope_mode`=1 the value at index i is code(i) − code(i−1) as a signed number. Index 0 yields no value and is skipped in both learning and scoring.
- R10: `fail` = `score` > `thresh`, where `thresh` is captured at `start`. A score equal to the limit passes.
- R11: If a window's summed band width is 0, its score is 2^`SCORE_W`−1 and `fail`=1 when its excess is non-zero. Otherwise its score is 0 and `fail`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted in ST_IDLE |
| op | input | 2 | Command: 0 clear, 1 learn, 2 test |
| slope_mode | input | 1 | 0 raw codes, 1 adjacent-code differences |
| sec_lo | input | SECS*IDX_W (24) | First index of each window, window k at bits k*6 |
| sec_hi | input | SECS*IDX_W (24) | Last index of each window, inclusive |
| thresh | input | SCORE_W (16) | Fail limit in 0.1 % units |
| smp_valid | input | 1 | Code on smp_data is accepted this cycle |
| smp_data | input | DATA_W (8) | Reconstructed sample code, unsigned |
| score_valid | output | 1 | One-cycle pulse per window result |
| score_sec | output | 2 | Window index of the current result |
| score | output | SCORE_W (16) | Deviation score in 0.1 % units |
| fail | output | 1 | Window result is outside the limit |

## Verification
A wrong edge in the band register shows up only in the next test run. It appears as a changed score, or a changed fail flag, in every window that covers the bad index. The bench therefore pairs each learned band with test records whose expected sums it works out index by index. A broken accumulator or divider step shows in the very first `score_valid` pulse of the window concerned. A wrong sequencing step shows as a missing, extra or out-of-order pulse on `score_sec` within the same run.

// File: rtl/envscore_pkg.sv
package envscore_pkg;

    localparam logic [1:0] OP_CLEAR = 2'd0;
    localparam logic [1:0] OP_LEARN = 2'd1;
    localparam logic [1:0] OP_TEST  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_LOAD    = 2'd2,
        ST_WAIT    = 2'd3
    } state_e;

endpackage

// File: rtl/es_env_store.sv
module es_env_store #(
    parameter int DEPTH = 64,
    parameter int VAL_W = 10,
    parameter int IDX_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [IDX_W-1:0]        idx,
    input  logic signed [VAL_W-1:0] val,
    output logic signed [VAL_W-1:0] rd_max,
    output logic signed [VAL_W-1:0] rd_min
);
    localparam logic signed [VAL_W-1:0] MOST_NEG = {1'b1, {(VAL_W-1){1'b0}}};
    localparam logic signed [VAL_W-1:0] MOST_POS = {1'b0, {(VAL_W-1){1'b1}}};

    logic signed [VAL_W-1:0] emax [DEPTH];
    logic signed [VAL_W-1:0] emin [DEPTH];
    logic [IDX_W-1:0]        wr_idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx_q <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                emax[k] <= MOST_NEG;
                emin[k] <= MOST_POS;
            end
        end else begin
            wr_idx_q <= idx;
            if (clr) begin
                for (int k = 0; k < DEPTH; k++) begin
                    emax[k] <= MOST_NEG;
                    emin[k] <= MOST_POS;
                end
            end else if (wr) begin
                if (val > emax[idx]) emax[idx] <= val;
                if (val < emin[idx]) emin[idx] <= val;
            end
        end
    end

    assign rd_max = emax[idx];
    assign rd_min = emin[idx];

    AST_ENV_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (emax[wr_idx_q] >= emin[wr_idx_q])); // R3
    AST_ENV_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (emax[0] == MOST_NEG && emin[DEPTH-1] == MOST_POS)); // R2
endmodule

// File: rtl/es_sec_accum.sv
module es_sec_accum #(
    parameter int IDX_W = 6,
    parameter int DEV_W = 11,
    parameter int ACC_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] lo,
    input  logic [IDX_W-1:0] hi,
    input  logic [DEV_W-1:0] dev,
    input  logic [DEV_W-1:0] span,
    output logic [ACC_W-1:0] dev_sum,
    output logic [ACC_W-1:0] span_sum
);
    logic hit;
    assign hit = en && (idx >= lo) && (idx <= hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_sum  <= '0;
            span_sum <= '0;
        end else if (clr) begin
            dev_sum  <= '0;
            span_sum <= '0;
        end else if (hit) begin
            dev_sum  <= dev_sum + ACC_W'(dev);
            span_sum <= span_sum + ACC_W'(span);
        end
    end

    AST_WINDOW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (idx > hi || idx < lo)) |=> $stable(dev_sum)); // R8
endmodule

// File: rtl/es_seq_div.sv
module es_seq_div #(
    parameter int ACC_W   = 17,
    parameter int NUM_W   = 27,
    parameter int SCORE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [NUM_W-1:0]   num,
    input  logic [ACC_W-1:0]   den,
    output logic               done,
    output logic [SCORE_W-1:0] quo
);
    localparam int CNT_W  = $clog2(NUM_W + 1);
    localparam int PROD_W = NUM_W + ACC_W;

    logic [NUM_W-1:0] num_q, qr;
    logic [ACC_W-1:0] den_q;
    logic [ACC_W:0]   rem, rem_sh, rem_nx;
    logic [CNT_W-1:0] cnt;
    logic             busy, q_bit;
    logic [NUM_W-1:0] q_full;

    always_comb begin
        rem_sh = {rem[ACC_W-1:0], qr[NUM_W-1]};
        q_bit  = (rem_sh >= {1'b0, den_q});
        rem_nx = q_bit ? (rem_sh - {1'b0, den_q}) : rem_sh;
        q_full = {qr[NUM_W-2:0], q_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q <= '0; den_q <= '0; qr <= '0; rem <= '0;
            cnt <= '0; busy <= 1'b0; done <= 1'b0; quo <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                num_q <= num; den_q <= den; qr <= num; rem <= '0; cnt <= '0;
                if (den == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    quo  <= (num != '0) ? '1 : '0;
                end else begin
                    busy <= 1'b1;
                end
            end else if (busy) begin
                rem <= rem_nx;
                qr  <= q_full;
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(NUM_W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    quo  <= (|q_full[NUM_W-1:SCORE_W]) ? '1 : q_full[SCORE_W-1:0];
                end
            end
        end
    end

    logic [PROD_W-1:0] lo_prod, hi_prod;
    assign lo_prod = PROD_W'(quo) * PROD_W'(den_q);
    assign hi_prod = (PROD_W'(quo) + PROD_W'(1)) * PROD_W'(den_q);

    AST_QUOTIENT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (done && den_q != '0 && quo != '1) |->
            (lo_prod <= PROD_W'(num_q) && PROD_W'(num_q) < hi_prod)); // R7
endmodule

// File: rtl/envelope_scorer.sv
module envelope_scorer
    import envscore_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 64,
    parameter int SECS    = 4,
    parameter int SCALE   = 1000,
    parameter int SCORE_W = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic [1:0]                         op,
    input  logic                               slope_mode,
    input  logic [SECS*$clog2(DEPTH)-1:0]      sec_lo,
    input  logic [SECS*$clog2(DEPTH)-1:0]      sec_hi,
    input  logic [SCORE_W-1:0]                 thresh,
    input  logic                               smp_valid,
    input  logic [DATA_W-1:0]                  smp_data,
    output logic                               score_valid,
    output logic [$clog2(SECS)-1:0]            score_sec,
    output logic [SCORE_W-1:0]                 score,
    output logic                               fail
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int SEC_W = $clog2(SECS);
    localparam int VAL_W = DATA_W + 2;
    localparam int DEV_W = VAL_W + 1;
    localparam int ACC_W = DEV_W + IDX_W;
    localparam int NUM_W = ACC_W + $clog2(SCALE + 1);

    state_e                  st_q, st_d;
    logic [1:0]              op_q;
    logic                    slope_q;
    logic [SCORE_W-1:0]      thr_q;
    logic [IDX_W-1:0]        idx_q;
    logic [DATA_W-1:0]       prev_q;
    logic [SEC_W-1:0]        sec_q;
    logic                    take, last, val_ok, wr_env, acc_en, acc_clr, env_clr;
    logic                    div_go, div_done;
    logic signed [VAL_W-1:0] cur_val, env_max, env_min;
    logic signed [VAL_W:0]   vx, mx, nx;
    logic [DEV_W-1:0]        dev, span;
    logic [ACC_W-1:0]        dsum [SECS];
    logic [ACC_W-1:0]        ssum [SECS];
    logic [NUM_W-1:0]        div_num;
    logic [SCORE_W-1:0]      div_quo;

    assign take    = (st_q == ST_COLLECT) && smp_valid;
    assign last    = take && (idx_q == IDX_W'(DEPTH - 1));
    assign val_ok  = !(slope_q && idx_q == '0);
    assign wr_env  = take && val_ok && (op_q == OP_LEARN);
    assign acc_en  = take && val_ok && (op_q == OP_TEST);
    assign acc_clr = (st_q == ST_IDLE) && start;
    assign env_clr = (st_q == ST_IDLE) && start && (op == OP_CLEAR);
    assign div_go  = (st_q == ST_LOAD);
    assign div_num = NUM_W'(dsum[sec_q]) * NUM_W'(SCALE);

    // value under test: raw code or signed step from the previous code
    always_comb begin
        if (slope_q) cur_val = $signed(VAL_W'(smp_data)) - $signed(VAL_W'(prev_q));
        else         cur_val = $signed(VAL_W'(smp_data));
    end

    // excess outside the band and band width at the current index
    always_comb begin
        vx  = {cur_val[VAL_W-1], cur_val};
        mx  = {env_max[VAL_W-1], env_max};
        nx  = {env_min[VAL_W-1], env_min};
        dev = '0;
        if (vx > mx)      dev = DEV_W'(vx - mx);
        else if (vx < nx) dev = DEV_W'(nx - vx);
        span = (mx >= nx) ? DEV_W'(mx - nx) : '0;
    end

    es_env_store #(.DEPTH(DEPTH), .VAL_W(VAL_W), .IDX_W(IDX_W)) env_i (
        .clk(clk), .rst_n(rst_n), .clr(env_clr), .wr(wr_env), .idx(idx_q),
        .val(cur_val), .rd_max(env_max), .rd_min(env_min));

    for (genvar k = 0; k < SECS; k++) begin : g_win
        es_sec_accum #(.IDX_W(IDX_W), .DEV_W(DEV_W), .ACC_W(ACC_W)) acc_i (
            .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en), .idx(idx_q),
            .lo(sec_lo[k*IDX_W +: IDX_W]), .hi(sec_hi[k*IDX_W +: IDX_W]),
            .dev(dev), .span(span), .dev_sum(dsum[k]), .span_sum(ssum[k]));
    end

    es_seq_div #(.ACC_W(ACC_W), .NUM_W(NUM_W), .SCORE_W(SCORE_W)) div_i (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(ssum[sec_q]),
        .done(div_done), .quo(div_quo));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start && (op == OP_LEARN || op == OP_TEST)) st_d = ST_COLLECT;
            ST_COLLECT: if (last) st_d = (op_q == OP_TEST) ? ST_LOAD : ST_IDLE;
            ST_LOAD:    st_d = ST_WAIT;
            ST_WAIT:    if (div_done) st_d = (sec_q == SEC_W'(SECS - 1)) ? ST_IDLE : ST_LOAD;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_CLEAR; slope_q <= 1'b0; thr_q <= '0;
            idx_q <= '0; prev_q <= '0; sec_q <= '0;
        end else begin
            if (st_q == ST_IDLE && start) begin
                op_q <= op; slope_q <= slope_mode; thr_q <= thresh; idx_q <= '0;
            end
            if (take) begin
                idx_q  <= idx_q + 1'b1;
                prev_q <= smp_data;
            end
            if (last)                              sec_q <= '0;
            else if (st_q == ST_WAIT && div_done)  sec_q <= sec_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            score_valid <= 1'b0; score_sec <= '0; score <= '0; fail <= 1'b0;
        end else begin
            score_valid <= 1'b0;
            if (st_q == ST_WAIT && div_done) begin
                score_valid <= 1'b1;
                score_sec   <= sec_q;
                score       <= div_quo;
                fail        <= (div_quo > thr_q) || (ssum[sec_q] == '0 && dsum[sec_q] != '0);
            end
        end
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid |=> !score_valid); // R8
    AST_FAIL_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (score_valid && score > thr_q) |-> fail); // R10
    AST_PASS_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (score_valid && score <= thr_q && score != '1) |-> !fail); // R10
endmodule

// File: tb/envelope_scorer_tb_top.sv
module envelope_scorer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int IDX_W = 6;
    localparam int SECS  = 4;
    localparam int SMAX  = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        slope_mode = 1'b0;
    logic [SECS*IDX_W-1:0] sec_lo = '0, sec_hi = '0;
    logic [15:0] thresh = '0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_data = '0;
    logic        score_valid;
    logic [1:0]  score_sec;
    logic [15:0] score;
    logic        fail;

    int n_checks = 0;
    int n_fails  = 0;
    int wave [DEPTH];
    int emx [DEPTH];
    int emn [DEPTH];
    int lo [SECS];
    int hi [SECS];

    always #(CLK_PERIOD/2) clk = ~clk;

    envelope_scorer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .slope_mode(slope_mode),
        .sec_lo(sec_lo), .sec_hi(sec_hi), .thresh(thresh), .smp_valid(smp_valid),
        .smp_data(smp_data), .score_valid(score_valid), .score_sec(score_sec),
        .score(score), .fail(fail));

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clamp(input int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    function automatic int base_at(input int i);
        if (i < 8)  return 20;
        if (i < 16) return 20 + (i - 8) * 25;
        if (i < 40) return 220;
        if (i < 48) return 220 - (i - 40) * 25;
        return 20;
    endfunction

    task automatic set_wave(input int off);
        for (int i = 0; i < DEPTH; i++) wave[i] = clamp(base_at(i) + off);
    endtask

    task automatic set_windows(input int l0, input int h0, input int l1, input int h1,
                               input int l2, input int h2, input int l3, input int h3);
        lo[0] = l0; hi[0] = h0; lo[1] = l1; hi[1] = h1;
        lo[2] = l2; hi[2] = h2; lo[3] = l3; hi[3] = h3;
        for (int k = 0; k < SECS; k++) begin
            sec_lo[k*IDX_W +: IDX_W] = IDX_W'(lo[k]);
            sec_hi[k*IDX_W +: IDX_W] = IDX_W'(hi[k]);
        end
    endtask

    function automatic int value_at(input int i, input bit slope);
        return slope ? wave[i] - wave[i-1] : wave[i];
    endfunction

    task automatic do_clear();
        @(negedge clk); start = 1'b1; op = 2'd0;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin emx[i] = -512; emn[i] = 511; end
    endtask

    task automatic drive_run(input logic [1:0] cmd, input bit slope);
        @(negedge clk); start = 1'b1; op = cmd; slope_mode = slope;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk); start = 1'b0; smp_valid = 1'b1; smp_data = 8'(wave[i]);
        end
        @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic do_learn(input bit slope);
        drive_run(2'd1, slope);
        for (int i = 0; i < DEPTH; i++) begin
            if (!(slope && i == 0)) begin
                if (value_at(i, slope) > emx[i]) emx[i] = value_at(i, slope);
                if (value_at(i, slope) < emn[i]) emn[i] = value_at(i, slope);
            end
        end
    endtask

    // test run; expected per-window result computed from the band model
    task automatic do_test(input bit slope, input int thr, input string tag);
        longint ds [SECS];
        longint ss [SECS];
        int got, guard;
        thresh = 16'(thr);
        for (int k = 0; k < SECS; k++) begin ds[k] = 0; ss[k] = 0; end
        for (int i = 0; i < DEPTH; i++) begin
            if (!(slope && i == 0)) begin
                int v, d;
                v = value_at(i, slope);
                d = (v > emx[i]) ? v - emx[i] : (v < emn[i]) ? emn[i] - v : 0;
                for (int k = 0; k < SECS; k++) begin
                    if (i >= lo[k] && i <= hi[k]) begin
                        ds[k] += d;
                        ss[k] += (emx[i] >= emn[i]) ? emx[i] - emn[i] : 0;
                    end
                end
            end
        end
        drive_run(2'd2, slope);
        got = 0; guard = 0;
        while (got < SECS && guard < 2000) begin
            if (score_valid) begin
                int es, ef;
                if (ss[got] == 0) begin
                    es = (ds[got] != 0) ? SMAX : 0;
                    ef = (ds[got] != 0) ? 1 : 0;
                end else begin
                    longint q;
                    q  = (ds[got] * 1000) / ss[got];
                    es = (q > SMAX) ? SMAX : int'(q);
                    ef = (es > thr) ? 1 : 0;
                end
                check({tag, " R8 window index"}, int'(score_sec), got);
                check({tag, " R7 score"}, int'(score), es);
                check({tag, " R10 fail flag"}, int'(fail), ef);
                got++;
            end
            @(negedge clk); guard++;
        end
        check({tag, " R8 window count"}, got, SECS);
    endtask

    task automatic t_reset();
        check("R1 score_valid in reset", int'(score_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 score_valid after reset", int'(score_valid), 0);
        check("R1 score after reset", int'(score), 0);
        check("R1 fail after reset", int'(fail), 0);
        for (int i = 0; i < DEPTH; i++) begin emx[i] = -512; emn[i] = 511; end
    endtask

    task automatic t_band();
        set_windows(0, 15, 16, 31, 32, 47, 48, 63);
        do_clear();
        set_wave(-3); do_learn(1'b0);
        set_wave(3);  do_learn(1'b0);
        set_wave(0);  do_test(1'b0, 60, "R3 R6 inside band");
        set_wave(3);  do_test(1'b0, 60, "R6 on band edge");
    endtask

    task automatic t_above();
        set_wave(5); do_test(1'b0, 60, "R4 above band");
    endtask

    task automatic t_below();
        set_wave(-7); do_test(1'b0, 60, "R5 below band");
    endtask

    task automatic t_mixed();
        set_wave(0);
        for (int i = 0; i < DEPTH; i++) wave[i] = clamp(base_at(i) + ((i % 2) ? 8 : -8));
        do_test(1'b0, 60, "R7 mixed excursions");
    endtask

    task automatic t_windows();
        set_windows(0, 9, 10, 40, 30, 50, 60, 63);
        set_wave(0); wave[35] = clamp(base_at(35) + 20); wave[61] = clamp(base_at(61) - 10);
        do_test(1'b0, 60, "R8 overlapping windows");
        set_windows(0, 15, 16, 31, 32, 47, 48, 63);
    endtask

    task automatic t_limit();
        set_wave(0); wave[3] = base_at(3) + 9;
        do_test(1'b0, 62, "R10 score equals limit");
        do_test(1'b0, 61, "R10 score above limit");
    endtask

    task automatic t_zero_span();
        do_clear();
        set_wave(0); do_learn(1'b0);
        do_test(1'b0, 60, "R11 R2 zero width no excess");
        wave[20] = base_at(20) + 3;
        do_test(1'b0, 60, "R11 R2 zero width with excess");
    endtask

    task automatic t_slope();
        do_clear();
        set_wave(0); do_learn(1'b1);
        set_wave(0); wave[20] = base_at(20) + 4; wave[50] = base_at(50) - 4; do_learn(1'b1);
        set_wave(5); do_test(1'b1, 60, "R9 offset invisible to slopes");
        set_wave(0); wave[30] = base_at(30) - 12; wave[52] = base_at(52) + 9;
        do_test(1'b1, 60, "R9 slope excursions");
        set_wave(0); wave[0] = 200;
        do_test(1'b1, 60, "R9 index zero skipped");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_band();
        t_above();
        t_below();
        t_mixed();
        t_windows();
        t_limit();
        t_zero_span();
        t_slope();
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule